// File: doc/BRIEF.md
# Free-Running Timer with Compare Channels

This block is a memory-mapped timer peripheral built around a double-word up-counter. The counter advances by one on every clock in which the timebase enable is high. The low word of the counter is compared for equality against four word-wide compare registers. Software schedules an event by reading the low counter word, adding a delay and writing the sum into a compare register. The sum wraps modulo the word size, so a target beyond the low word's wrap point matches after the wrap.

When a channel matches, its match flag sets and stays set until software writes a one to that flag's bit in the status word. Each channel's interrupt output follows its own flag. The bus is a simple single-cycle register interface. A read returns its data one cycle after the address is presented. Writes take effect at the clock edge on which they are presented.

Top module: `free_timer_cmp`

## Requirements
- R1: Reset clears the counter, all compare registers, all match flags, all interrupt outputs and the read data register.
- R2: The double-word counter advances by exactly one on each cycle in which `tick_en` is high and holds otherwise. A read of offset 0x04 (low word) or 0x08 (high word) returns, in the following cycle, the value the counter had in the cycle the address was presented.
- R3: When the low word is all ones and a tick occurs, the low word becomes zero and the high word increments on the same edge.
- R4: Compare register n sits at offset 0x0C + 4*n (n = 0..3). It is fully writable and reads back the full written word.
- R5: A channel's flag sets on the tick in which the incremented low word equals that channel's compare value. No flag sets on a cycle without a tick.
- R6: Interrupt output bit n is high exactly while flag n is set. The flag stays set after the counter moves past the compare value.
- R7: Status is at offset 0x00, with flag n in bit n. Writing 1 to bit n clears flag n, and writing 0 leaves it unchanged. Status bits above the channel count read as zero and ignore writes.
- R8: If a clear of flag n and a new match on channel n occur in the same cycle, the flag ends up set.
- R9: A compare value below the current low word matches once the low word has wrapped through zero and reaches that value.
- R10: Writes to the counter offsets have no effect. Reads of offsets beyond the last compare register return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Timebase enable; counter advances when high |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | WORD_W | Write data |
| bus_rdata | output | WORD_W | Read data, valid the cycle after a read |
| irq | output | NUM_CH | Per-channel interrupt, high while the flag is set |

## Verification
A counter that skips or stalls shows up in the next low-word read. It also moves every later match by the same amount, so the interrupt edges drift from the cycles the bench predicts. A lost carry appears in the high-word read taken right after the low word wraps. A flag that fails to set, sets early or is not cleared shows on `irq` at the first clock edge after the bad update. It is caught at the falling edge that follows, because the bench compares every interrupt bit against its model on every cycle.

// File: rtl/ftc_pkg.sv
package ftc_pkg;

  // Word index (byte offset / 4) of each register; channel n adds n to the base
  localparam int unsigned IDX_STATUS   = 0;
  localparam int unsigned IDX_CNT_LO   = 1;
  localparam int unsigned IDX_CNT_HI   = 2;
  localparam int unsigned IDX_CMP_BASE = 3;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;

  function automatic acc_e classify(input logic sel, input logic we);
    if (!sel) return ACC_IDLE;
    return we ? ACC_WRITE : ACC_READ;
  endfunction

endpackage

// File: rtl/ftc_counter.sv
module ftc_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_en,
  output logic [W-1:0] cnt_lo,
  output logic [W-1:0] cnt_hi,
  output logic [W-1:0] lo_inc
);

  logic [W-1:0] lo_q;
  logic [W-1:0] hi_q;
  logic         lo_full;

  assign lo_inc  = lo_q + W'(1);
  assign lo_full = &lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (tick_en) begin
      lo_q <= lo_inc;
      if (lo_full) hi_q <= hi_q + W'(1);
    end
  end

  assign cnt_lo = lo_q;
  assign cnt_hi = hi_q;

  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    tick_en |=> {hi_q, lo_q} == ($past({hi_q, lo_q}) + (2*W)'(1)));

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> $stable(lo_q) && $stable(hi_q));

  p_carry_r3: assert property (@(posedge clk) disable iff (rst)
    (tick_en && (&lo_q)) |=> (lo_q == '0) && (hi_q == $past(hi_q) + W'(1)));

endmodule

// File: rtl/ftc_channel.sv
module ftc_channel #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_en,
  input  logic [W-1:0] cnt_lo,
  input  logic [W-1:0] lo_inc,
  input  logic         cmp_we,
  input  logic [W-1:0] cmp_wdata,
  input  logic         clr,
  output logic [W-1:0] cmp_q,
  output logic         flag_q
);

  logic hit;

  assign hit = tick_en && (lo_inc == cmp_q);

  always_ff @(posedge clk) begin
    if (rst)         cmp_q <= '0;
    else if (cmp_we) cmp_q <= cmp_wdata;
  end

  // a match in the same cycle as a clear keeps the flag set
  always_ff @(posedge clk) begin
    if (rst)      flag_q <= 1'b0;
    else if (hit) flag_q <= 1'b1;
    else if (clr) flag_q <= 1'b0;
  end

  p_rise_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(tick_en) && (cnt_lo == $past(cmp_q)));

  p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr) |=> flag_q);

  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (clr && !tick_en) |=> !flag_q);

  p_setwins_r8: assert property (@(posedge clk) disable iff (rst)
    (clr && tick_en && (lo_inc == cmp_q)) |=> flag_q);

endmodule

// File: rtl/ftc_bus.sv
module ftc_bus
  import ftc_pkg::*;
#(
  parameter int W      = 32,
  parameter int NCH    = 4,
  parameter int ADDR_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel,
  input  logic             we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]     wdata,
  input  logic [NCH-1:0]   flags,
  input  logic [W-1:0]     cnt_lo,
  input  logic [W-1:0]     cnt_hi,
  input  logic [NCH*W-1:0] cmp_all,
  output logic [NCH-1:0]   cmp_we,
  output logic [NCH-1:0]   clr_mask,
  output logic [W-1:0]     rdata
);

  localparam int IDX_W    = ADDR_W - 2;
  localparam int LAST_IDX = IDX_CMP_BASE + NCH - 1;

  acc_e             acc;
  logic [IDX_W-1:0] word_idx;
  logic [1:0]       unused_byte_lsb;
  logic [W-1:0]     rd_next;

  assign acc             = classify(sel, we);
  assign word_idx        = addr[ADDR_W-1:2];
  assign unused_byte_lsb = addr[1:0];

  genvar ch;
  generate
    for (ch = 0; ch < NCH; ch++) begin : g_wdec
      assign cmp_we[ch] = (acc == ACC_WRITE) && (word_idx == IDX_W'(IDX_CMP_BASE + ch));
    end
  endgenerate

  assign clr_mask = ((acc == ACC_WRITE) && (word_idx == IDX_W'(IDX_STATUS)))
                    ? wdata[NCH-1:0] : '0;

  always_comb begin
    rd_next = '0;
    if (word_idx == IDX_W'(IDX_STATUS))      rd_next[NCH-1:0] = flags;
    else if (word_idx == IDX_W'(IDX_CNT_LO)) rd_next = cnt_lo;
    else if (word_idx == IDX_W'(IDX_CNT_HI)) rd_next = cnt_hi;
    for (int c = 0; c < NCH; c++) begin
      if (word_idx == IDX_W'(IDX_CMP_BASE + c)) rd_next = cmp_all[c*W +: W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                  rdata <= '0;
    else if (acc == ACC_READ) rdata <= rd_next;
  end

  p_stat_upper_r7: assert property (@(posedge clk) disable iff (rst)
    ((acc == ACC_READ) && (word_idx == IDX_W'(IDX_STATUS))) |=> (rdata[W-1:NCH] == '0));

  p_unmapped_r10: assert property (@(posedge clk) disable iff (rst)
    ((acc == ACC_READ) && (word_idx > IDX_W'(LAST_IDX))) |=> (rdata == '0));

  p_onehot_we_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cmp_we));

endmodule

// File: rtl/free_timer_cmp.sv
module free_timer_cmp #(
  parameter int WORD_W = 32,
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] irq
);

  logic [WORD_W-1:0]        cnt_lo;
  logic [WORD_W-1:0]        cnt_hi;
  logic [WORD_W-1:0]        lo_inc;
  logic [NUM_CH-1:0]        cmp_we;
  logic [NUM_CH-1:0]        clr_mask;
  logic [NUM_CH-1:0]        flags;
  logic [NUM_CH*WORD_W-1:0] cmp_all;

  ftc_counter #(.W(WORD_W)) u_counter (
    .clk     (clk),
    .rst     (rst),
    .tick_en (tick_en),
    .cnt_lo  (cnt_lo),
    .cnt_hi  (cnt_hi),
    .lo_inc  (lo_inc)
  );

  genvar ch;
  generate
    for (ch = 0; ch < NUM_CH; ch++) begin : g_ch
      ftc_channel #(.W(WORD_W)) u_channel (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .cnt_lo    (cnt_lo),
        .lo_inc    (lo_inc),
        .cmp_we    (cmp_we[ch]),
        .cmp_wdata (bus_wdata),
        .clr       (clr_mask[ch]),
        .cmp_q     (cmp_all[ch*WORD_W +: WORD_W]),
        .flag_q    (flags[ch])
      );
    end
  endgenerate

  ftc_bus #(.W(WORD_W), .NCH(NUM_CH), .ADDR_W(ADDR_W)) u_bus (
    .clk      (clk),
    .rst      (rst),
    .sel      (bus_sel),
    .we       (bus_we),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .flags    (flags),
    .cnt_lo   (cnt_lo),
    .cnt_hi   (cnt_hi),
    .cmp_all  (cmp_all),
    .cmp_we   (cmp_we),
    .clr_mask (clr_mask),
    .rdata    (bus_rdata)
  );

  assign irq = flags;

  p_irq_reset_r1: assert property (@(posedge clk)
    rst |=> (irq == '0) && (bus_rdata == '0));

endmodule

// File: tb/test_free_timer_cmp.sv
`timescale 1ns/1ps
module test_free_timer_cmp;

  localparam int W  = 8;
  localparam int NC = 4;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick_en = 1'b0;
  logic          bus_sel = 1'b0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [W-1:0]  bus_wdata = '0;
  logic [W-1:0]  bus_rdata;
  logic [NC-1:0] irq;

  int    errors = 0;
  int    checks = 0;
  int    ticks = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  free_timer_cmp #(.WORD_W(W), .NUM_CH(NC), .ADDR_W(AW)) i_free_timer_cmp (
    .clk(clk), .rst(rst), .tick_en(tick_en), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // ---------------- reference model built from the requirements ----------------
  logic [2*W-1:0] m_cnt;
  logic [W-1:0]   m_cmp [NC];
  logic [NC-1:0]  m_flag;
  logic [W-1:0]   m_rd;
  logic           m_rdv;

  function automatic logic [W-1:0] exp_read(input logic [AW-1:0] a);
    int idx = int'(a[AW-1:2]);
    if (idx == 0) return {{(W-NC){1'b0}}, m_flag};
    if (idx == 1) return m_cnt[W-1:0];
    if (idx == 2) return m_cnt[2*W-1:W];
    if (idx >= 3 && idx < 3 + NC) return m_cmp[idx-3];
    return '0;
  endfunction

  always @(posedge clk) begin
    logic [2*W-1:0] nxt;
    if (rst) begin
      m_cnt  <= '0;
      m_flag <= '0;
      m_rd   <= '0;
      m_rdv  <= 1'b0;
      for (int c = 0; c < NC; c++) m_cmp[c] <= '0;
    end else begin
      nxt = m_cnt + 1;
      m_rdv <= bus_sel && !bus_we;
      if (bus_sel && !bus_we) m_rd <= exp_read(bus_addr);
      if (tick_en) m_cnt <= nxt;
      for (int c = 0; c < NC; c++) begin
        if (tick_en && nxt[W-1:0] == m_cmp[c])
          m_flag[c] <= 1'b1;
        else if (bus_sel && bus_we && bus_addr[AW-1:2] == 0 && bus_wdata[c])
          m_flag[c] <= 1'b0;
        if (bus_sel && bus_we && int'(bus_addr[AW-1:2]) == 3 + c)
          m_cmp[c] <= bus_wdata;
      end
    end
  end

  task automatic chk(input logic [W-1:0] got, input logic [W-1:0] exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  // every cycle: interrupts and read data against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(W'(irq), W'(m_flag), {cur_req, " irq"});
      if (m_rdv) chk(bus_rdata, m_rd, {cur_req, " rdata"});
    end
  end

  // ---------------- bus tasks (driven at the falling edge) ----------------
  task automatic idle(input int n, input bit t);
    for (int i = 0; i < n; i++) begin
      tick_en = t;
      @(negedge clk);
      ticks += int'(t);
    end
    tick_en = 1'b0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d, input bit t);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; tick_en = t;
    @(negedge clk);
    ticks += int'(t);
    bus_sel = 1'b0; bus_we = 1'b0; tick_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a; tick_en = 1'b0;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [W-1:0] wval [NC];
    logic [W-1:0] lo0;
    int hi0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: everything zero after reset
    cur_req = "R1";
    chk(W'(irq), '0, "R1 irq after reset");
    for (int a = 0; a < 8; a++) begin
      rd(AW'(a * 4));
      chk(bus_rdata, '0, "R1 reset read");
    end

    // R4: compare registers write and read back
    cur_req = "R4";
    for (int c = 0; c < NC; c++) begin
      wval[c] = W'($urandom());
      wr(AW'(12 + 4 * c), wval[c], 1'b0);
    end
    for (int c = 0; c < NC; c++) begin
      rd(AW'(12 + 4 * c));
      chk(bus_rdata, wval[c], "R4 compare readback");
    end

    // R2: counting only under tick_en
    cur_req = "R2";
    for (int i = 0; i < 120; i++) idle(1, 1'($urandom_range(0, 1)));
    rd(5'h04);
    chk(bus_rdata, W'(ticks), "R2 low word");
    rd(5'h08);
    chk(bus_rdata, W'(ticks >> W), "R2 high word");
    idle(7, 1'b0);
    rd(5'h04);
    chk(bus_rdata, W'(ticks), "R2 hold without tick");

    // R5: directed match three ticks ahead on channel 2
    cur_req = "R5";
    lo0 = W'(ticks);
    wr(5'h14, lo0 + W'(3), 1'b0);
    wr(5'h00, 8'h0F, 1'b0);
    idle(2, 1'b1);
    chk(W'(irq[2]), '0, "R5 no match early");
    idle(1, 1'b1);
    chk(W'(irq[2]), W'(1), "R5 match on target tick");

    // R6: flag persists as counter moves on
    cur_req = "R6";
    idle(10, 1'b1);
    chk(W'(irq[2]), W'(1), "R6 sticky irq");

    // R7: zero bits and upper bits do nothing; one bit clears
    cur_req = "R7";
    wr(5'h00, 8'hF0, 1'b0);
    chk(W'(irq[2]), W'(1), "R7 write zero keeps flag");
    rd(5'h00);
    chk(bus_rdata & 8'hF0, '0, "R7 upper status bits zero");
    chk(W'(bus_rdata[2]), W'(1), "R7 status bit 2");
    wr(5'h00, 8'h04, 1'b0);
    chk(W'(irq[2]), '0, "R7 write one clears");

    // R8: clear and match together on channel 1
    cur_req = "R8";
    wr(5'h10, W'(ticks) + W'(1), 1'b0);
    wr(5'h00, 8'h02, 1'b1);
    chk(W'(irq[1]), W'(1), "R8 set wins over clear");
    wr(5'h00, 8'h02, 1'b0);
    chk(W'(irq[1]), '0, "R8 later clear");

    // R9: target behind the current low word matches after wrap
    cur_req = "R9";
    wr(5'h18, W'(ticks) - W'(5), 1'b0);
    wr(5'h00, 8'h08, 1'b0);
    idle(250, 1'b1);
    chk(W'(irq[3]), '0, "R9 no match before wrap");
    idle(1, 1'b1);
    chk(W'(irq[3]), W'(1), "R9 match after wrap");

    // R3: carry into high word on the same edge
    cur_req = "R3";
    idle((255 - (ticks % 256)), 1'b1);
    rd(5'h04);
    chk(bus_rdata, 8'hFF, "R3 low word at top");
    hi0 = ticks >> W;
    idle(1, 1'b1);
    rd(5'h04);
    chk(bus_rdata, '0, "R3 low wraps to zero");
    rd(5'h08);
    chk(bus_rdata, W'(hi0 + 1), "R3 high increments");

    // R10: counter words are not writable, unmapped reads zero
    cur_req = "R10";
    wr(5'h04, 8'h5A, 1'b0);
    wr(5'h08, 8'hA5, 1'b0);
    rd(5'h04);
    chk(bus_rdata, W'(ticks), "R10 low word unchanged");
    rd(5'h08);
    chk(bus_rdata, W'(ticks >> W), "R10 high word unchanged");
    rd(5'h1C);
    chk(bus_rdata, '0, "R10 unmapped read");

    // random mix, checked by the model every cycle
    cur_req = "R5";
    for (int i = 0; i < 3000; i++) begin
      int op = $urandom_range(0, 3);
      bit t = 1'($urandom_range(0, 1));
      logic [AW-1:0] a = AW'($urandom_range(0, 7) * 4);
      if (op == 0) idle(1, t);
      else if (op == 1) begin
        tick_en = t;
        rd(a);
        ticks += int'(t);
      end else wr(a, W'($urandom()), t);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial void'($urandom(32'd1234));

endmodule